// File: doc/BRIEF.md
# Watchdog Clock-Select Guard Register File

This block is the small register file of a clock and power management unit that decides which clock sources feed the PLL path, the real-time interrupt timer and the watchdog. It holds a clock-select register, a watchdog configuration register, the synthesizer and reference-divider settings, and two status flags: oscillator valid and PLL locked. Software reaches all of it through a plain register bus with an address, write data, a write strobe and combinational read data.

Most clock-select bits can be written at any time. The two bits that choose the watchdog clock are guarded. In normal mode they stay writable only until the watchdog configuration register has been written. Once that has happened, they are locked, and the configuration register itself accepts no more writes in normal mode. The oscillator-valid flag controls the guard as well. The low watchdog clock-select bit can only be set while the flag is high. When the flag is lost, hardware clears that bit and the selection opens for one more clock-select write. Rewriting either divider register drops both status flags, and so does a loss of PLL lock.

A special-mode input lifts the write-once rules, so that test software can rewrite the watchdog configuration and both watchdog clock-select bits freely.

Top module: `cpm_clksel_regs`

## Requirements
- R1: After reset, every register reads 0. The address map is: 0 clock select, 1 watchdog configuration, 2 synthesizer, 3 reference divider, 4 status. The status register shows the oscillator-valid flag in bit 0 and the PLL-lock flag in bit 1.
- R2: In the clock-select register, bits 7 (PLL select), 6 (pseudo stop), 5 (watchdog stop-mode clock disable), 3 (RTI run in pseudo stop), 2 (watchdog run in pseudo stop) and 1 (RTI clock select) take every write and read back the written value.
- R3: The watchdog clock-select bits are bit 0 (select 0) and bit 4 (select 1). In normal mode they follow writes until the first watchdog configuration write. After that, clock-select writes leave both bits unchanged.
- R4: Bit 0 of the clock-select register becomes 1 only if the oscillator-valid flag is 1 when it is written. A write of 1 while the flag is 0 gives 0.
- R5: When the oscillator-valid flag drops from 1 to 0, hardware clears bit 0 of the clock-select register on the same edge.
- R6: Once the watchdog is configured, a drop of the oscillator-valid flag reopens the watchdog clock-select bits for exactly one further normal-mode clock-select write. That write relocks them.
- R7: A write to the synthesizer or reference-divider register clears both status flags on the edge that takes the write. The written value reads back.
- R8: The PLL-lock flag follows the PLL-lock input. A low PLL-lock input or a low oscillator-good input clears the oscillator-valid flag. The flag sets again only while oscillator-good is high and the PLL-lock flag is set. Clearing wins over setting.
- R9: In normal mode the watchdog configuration register accepts only its first write. In special mode it accepts every write, and the watchdog clock-select bits are writable whatever the lock state. Special-mode writes neither arm nor consume the lock.
- R10: Suppose a clock-select write that sets bit 0 arrives on the same edge on which the oscillator-valid flag is lost. Then bit 0 ends at 0, and the selection is reopened for the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| special_mode | input | 1 | High lifts the write-once rules |
| osc_good | input | 1 | Oscillator reported stable |
| pll_locked | input | 1 | PLL reports lock |

## Verification
Two events can land on the same edge: a software write to the clock-select register, and a hardware loss of the oscillator-valid flag. The bench provokes this by driving a clock-select write of 0x11 in the same cycle it pulls oscillator-good low, while the watchdog clock selection is locked. It then reads the register back. Bit 0 must be 0, bit 4 must hold its locked value, and a following write must be accepted because the selection has reopened. The lock-release edge caused by a divider write is exercised in the same way: the bench reads the status and the clock-select value in the cycle right after that write.

// File: rtl/cpm_clksel_pkg.sv
package cpm_clksel_pkg;

    // Clock-select register bit positions
    localparam int CS_WDSEL0    = 0;
    localparam int CS_RTISEL    = 1;
    localparam int CS_WDPSTP    = 2;
    localparam int CS_RTIPSTP   = 3;
    localparam int CS_WDSEL1    = 4;
    localparam int CS_WDSTOPDIS = 5;
    localparam int CS_PSTOP     = 6;
    localparam int CS_PLLSEL    = 7;

    // Register addresses
    localparam int AD_CLKSEL = 0;
    localparam int AD_WDCFG  = 1;
    localparam int AD_SYNTH  = 2;
    localparam int AD_REFDIV = 3;
    localparam int AD_STATUS = 4;

    // Status register bit positions
    localparam int ST_OSCVLD = 0;
    localparam int ST_PLLLCK = 1;

    typedef struct packed {
        logic lock;
        logic vld;
    } flags_t;

endpackage

// File: rtl/cpm_flag_unit.sv
module cpm_flag_unit
    import cpm_clksel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic div_wr,
    input  logic osc_good,
    input  logic pll_locked,
    output logic pll_lock_q,
    output logic osc_valid_q,
    output logic osc_lost
);

    flags_t fl_d, fl_q;
    logic   clr;

    always_comb begin
        fl_d     = fl_q;
        clr      = div_wr | ~osc_good | ~pll_locked;
        fl_d.lock = div_wr ? 1'b0 : pll_locked;
        if (clr) begin
            fl_d.vld = 1'b0;
        end else if (osc_good && fl_q.lock) begin
            fl_d.vld = 1'b1;
        end
        osc_lost = fl_q.vld & clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign pll_lock_q  = fl_q.lock;
    assign osc_valid_q = fl_q.vld;

endmodule

// File: rtl/cpm_wdcfg_reg.sv
module cpm_wdcfg_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              special,
    output logic [DATA_W-1:0] cfg,
    output logic              done,
    output logic              arm
);

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              done;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        arm  = wr & ~special & ~wd_q.done;
        if (wr && (special || !wd_q.done)) begin
            wd_d.cfg = wdata;
        end
        if (arm) begin
            wd_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign cfg  = wd_q.cfg;
    assign done = wd_q.done;

endmodule

// File: rtl/cpm_clksel_reg.sv
module cpm_clksel_reg
    import cpm_clksel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              special,
    input  logic              osc_valid,
    input  logic              osc_lost,
    input  logic              wd_arm,
    input  logic              wd_done,
    output logic [DATA_W-1:0] sel,
    output logic              locked
);

    localparam logic [DATA_W-1:0] GUARD_MASK =
        DATA_W'((1 << CS_WDSEL0) | (1 << CS_WDSEL1));
    localparam logic [DATA_W-1:0] FREE_MASK = ~GUARD_MASK;

    typedef struct packed {
        logic [DATA_W-1:0] sel;
        logic              locked;
    } cs_t;

    cs_t  cs_d, cs_q;
    logic sel_open;

    always_comb begin
        cs_d     = cs_q;
        sel_open = special | ~cs_q.locked;

        if (wr) begin
            cs_d.sel = (cs_q.sel & GUARD_MASK) | (wdata & FREE_MASK);
            if (sel_open) begin
                cs_d.sel[CS_WDSEL1] = wdata[CS_WDSEL1];
                cs_d.sel[CS_WDSEL0] = wdata[CS_WDSEL0] & osc_valid;
            end
        end
        if (osc_lost) begin
            cs_d.sel[CS_WDSEL0] = 1'b0;
        end

        if (osc_lost) begin
            cs_d.locked = 1'b0;
        end else if (wd_arm) begin
            cs_d.locked = 1'b1;
        end else if (wr && wd_done && !special && !cs_q.locked) begin
            cs_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign sel    = cs_q.sel;
    assign locked = cs_q.locked;

endmodule

// File: rtl/cpm_clksel_regs.sv
module cpm_clksel_regs
    import cpm_clksel_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              special_mode,
    input  logic              osc_good,
    input  logic              pll_locked
);

    localparam logic [ADDR_W-1:0] A_CS  = ADDR_W'(AD_CLKSEL);
    localparam logic [ADDR_W-1:0] A_WD  = ADDR_W'(AD_WDCFG);
    localparam logic [ADDR_W-1:0] A_SY  = ADDR_W'(AD_SYNTH);
    localparam logic [ADDR_W-1:0] A_RD  = ADDR_W'(AD_REFDIV);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(AD_STATUS);

    typedef struct packed {
        logic [DATA_W-1:0] synth;
        logic [DATA_W-1:0] refdiv;
    } div_t;

    div_t div_d, div_q;

    logic wr_cs, wr_wd, wr_sy, wr_rd, div_wr;
    logic pll_lock_q, osc_valid_q, osc_lost;
    logic [DATA_W-1:0] clksel_q, wdcfg_q;
    logic wd_done, wd_arm, sel_locked;

    always_comb begin
        wr_cs  = bus_we && (bus_addr == A_CS);
        wr_wd  = bus_we && (bus_addr == A_WD);
        wr_sy  = bus_we && (bus_addr == A_SY);
        wr_rd  = bus_we && (bus_addr == A_RD);
        div_wr = wr_sy | wr_rd;

        div_d = div_q;
        if (wr_sy) div_d.synth  = bus_wdata;
        if (wr_rd) div_d.refdiv = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    cpm_flag_unit u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_wr     (div_wr),
        .osc_good   (osc_good),
        .pll_locked (pll_locked),
        .pll_lock_q (pll_lock_q),
        .osc_valid_q(osc_valid_q),
        .osc_lost   (osc_lost)
    );

    cpm_wdcfg_reg #(.DATA_W(DATA_W)) u_wdcfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_wd),
        .wdata  (bus_wdata),
        .special(special_mode),
        .cfg    (wdcfg_q),
        .done   (wd_done),
        .arm    (wd_arm)
    );

    cpm_clksel_reg #(.DATA_W(DATA_W)) u_clksel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cs),
        .wdata    (bus_wdata),
        .special  (special_mode),
        .osc_valid(osc_valid_q),
        .osc_lost (osc_lost),
        .wd_arm   (wd_arm),
        .wd_done  (wd_done),
        .sel      (clksel_q),
        .locked   (sel_locked)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CS: bus_rdata = clksel_q;
            A_WD: bus_rdata = wdcfg_q;
            A_SY: bus_rdata = div_q.synth;
            A_RD: bus_rdata = div_q.refdiv;
            A_ST: begin
                bus_rdata[ST_OSCVLD] = osc_valid_q;
                bus_rdata[ST_PLLLCK] = pll_lock_q;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpm_clksel_regs_chk.sv
module cpm_clksel_regs_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              special_mode,
    input logic              osc_good,
    input logic              sel0,
    input logic              sel1,
    input logic [DATA_W-1:0] wdcfg,
    input logic              sel_locked,
    input logic              osc_valid,
    input logic              pll_lock
);

    p_div_clears_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3)))
        |=> (!osc_valid && !pll_lock));

    p_sel0_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel0 |-> osc_valid);

    p_loss_clears_sel0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_valid) |-> !sel0);

    p_loss_reopens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_valid) |-> !sel_locked);

    p_valid_needs_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_valid) |-> ($past(osc_good) && $past(pll_lock)));

    p_locked_sel1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(0) && !special_mode && sel_locked)
        |=> (sel1 == $past(sel1)));

    p_wdcfg_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(1) && !special_mode && sel_locked)
        |=> $stable(wdcfg));

endmodule

bind cpm_clksel_regs cpm_clksel_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .special_mode(special_mode),
    .osc_good    (osc_good),
    .sel0        (clksel_q[0]),
    .sel1        (clksel_q[4]),
    .wdcfg       (wdcfg_q),
    .sel_locked  (sel_locked),
    .osc_valid   (osc_valid_q),
    .pll_lock    (pll_lock_q)
);

// File: tb/sim_cpm_clksel_regs.sv
module sim_cpm_clksel_regs;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       special_mode = 1'b0;
    logic       osc_good = 1'b0;
    logic       pll_locked = 1'b1;

    int n_run  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpm_clksel_regs u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .special_mode(special_mode),
        .osc_good    (osc_good),
        .pll_locked  (pll_locked)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 clksel", 3'd0, 8'h00);
        rd_chk("R1 wdcfg",  3'd1, 8'h00);
        rd_chk("R1 synth",  3'd2, 8'h00);
        rd_chk("R1 refdiv", 3'd3, 8'h00);
        rd_chk("R1 status", 3'd4, 8'h00);
    endtask

    task automatic t_free_bits;
        wr(3'd0, 8'hEE);
        rd_chk("R2 free bits set", 3'd0, 8'hEE);
        wr(3'd0, 8'h00);
        rd_chk("R2 free bits clear", 3'd0, 8'h00);
    endtask

    task automatic t_osc_gate;
        wr(3'd0, 8'h01);
        rd_chk("R4 sel0 blocked without osc", 3'd0, 8'h00);
        osc_good = 1'b1;
        wait_cyc(3);
        rd_chk("R8 flags set", 3'd4, 8'h03);
        wr(3'd0, 8'h11);
        rd_chk("R3 sel bits open before config", 3'd0, 8'h11);
    endtask

    task automatic t_loss_clear;
        @(negedge clk);
        osc_good = 1'b0;
        @(negedge clk);
        rd_chk("R5 sel0 cleared on loss", 3'd0, 8'h10);
        osc_good = 1'b1;
        wait_cyc(3);
    endtask

    task automatic t_lock;
        wr(3'd0, 8'h11);
        rd_chk("R3 sel before config", 3'd0, 8'h11);
        wr(3'd1, 8'h44);
        rd_chk("R9 first cfg write", 3'd1, 8'h44);
        wr(3'd1, 8'h07);
        rd_chk("R9 second cfg write ignored", 3'd1, 8'h44);
        wr(3'd0, 8'h80);
        rd_chk("R3 locked keeps sel bits", 3'd0, 8'h91);
        wr(3'd0, 8'h00);
        rd_chk("R3 locked keeps sel bits on clear", 3'd0, 8'h11);
    endtask

    task automatic t_div_reopen;
        wr(3'd2, 8'h01);
        rd_chk("R7 synth write clears flags", 3'd4, 8'h00);
        rd_chk("R7 synth readback", 3'd2, 8'h01);
        rd_chk("R5 sel0 cleared by div write", 3'd0, 8'h10);
        wait_cyc(3);
        rd_chk("R8 flags return", 3'd4, 8'h03);
        wr(3'd0, 8'h01);
        rd_chk("R6 reopened write accepted", 3'd0, 8'h01);
        wr(3'd0, 8'h10);
        rd_chk("R6 relocked after one write", 3'd0, 8'h01);
        wr(3'd3, 8'h80);
        rd_chk("R7 refdiv write clears flags", 3'd4, 8'h00);
        rd_chk("R7 refdiv readback", 3'd3, 8'h80);
        rd_chk("R5 sel0 cleared by refdiv", 3'd0, 8'h00);
        wait_cyc(3);
    endtask

    task automatic t_pll_drop;
        @(negedge clk);
        pll_locked = 1'b0;
        @(negedge clk);
        rd_chk("R8 pll drop clears both", 3'd4, 8'h00);
        osc_good   = 1'b0;
        pll_locked = 1'b1;
        wait_cyc(3);
        rd_chk("R8 no valid without osc_good", 3'd4, 8'h02);
        osc_good = 1'b1;
        wait_cyc(3);
        rd_chk("R8 valid after osc_good", 3'd4, 8'h03);
        wr(3'd0, 8'h10);
        rd_chk("R6 reopen after pll drop", 3'd0, 8'h10);
    endtask

    task automatic t_collision;
        @(negedge clk);
        bus_addr  = 3'd0;
        bus_wdata = 8'h11;
        bus_we    = 1'b1;
        osc_good  = 1'b0;
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk("R10 write with loss leaves sel0 low", 3'd0, 8'h10);
        rd_chk("R10 flag lost", 3'd4, 8'h02);
        osc_good = 1'b1;
        wait_cyc(3);
        wr(3'd0, 8'h01);
        rd_chk("R10 reopened after collision", 3'd0, 8'h01);
    endtask

    task automatic t_special;
        @(negedge clk);
        special_mode = 1'b1;
        wr(3'd1, 8'h22);
        rd_chk("R9 special cfg rewrite", 3'd1, 8'h22);
        wr(3'd0, 8'h10);
        rd_chk("R9 special sel write", 3'd0, 8'h10);
        wr(3'd0, 8'h00);
        rd_chk("R9 special sel second write", 3'd0, 8'h00);
        @(negedge clk);
        special_mode = 1'b0;
        wr(3'd1, 8'h55);
        rd_chk("R9 normal cfg ignored", 3'd1, 8'h22);
        wr(3'd0, 8'h11);
        rd_chk("R3 normal sel locked", 3'd0, 8'h00);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset;
        t_free_bits;
        t_osc_gate;
        t_loss_clear;
        t_lock;
        t_div_reopen;
        t_pll_drop;
        t_collision;
        t_special;
        wait_cyc(2);
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            finish_run;
        end
    end

endmodule